// File: doc/BRIEF.md
# Bridge Command Register Request Gate

This block sits in one port of a PCI-style bridge and owns the low byte of its command register together with one status bit. The command bits decide three things. The first is whether downstream memory accesses are claimed. The second is whether downstream I/O accesses are claimed. The third is whether requests from the secondary side are allowed onto the primary side as real transactions.

When bus mastering is switched off, upstream traffic is not thrown away. Each request is rewritten into a cycle that cannot disturb the system. A write-class request becomes a memory write to a fixed legacy address with every byte enable cleared. A read-class request becomes a memory read of that address. The block then answers the read itself with an Unsupported Request completion.

A master data parity error input sets a status bit, but only while the parity response enable bit is on. Software clears that status bit by writing 1 to it. Downstream completions are never gated by the command bits.

Top module: `bridge_cmd_gate`

## Requirements
- R1: After reset, the command view and the status view both read 0, no forwarded request is valid, no completion is valid, and up_ready is 1.
- R2: With cfg_sel=0 a write stores only bit 0 (I/O enable), bit 1 (memory enable), bit 2 (bus master enable) and bit 6 (parity response enable). Bits 3, 4 and 5 and bits 7 to 15 always read 0, whatever was written to them.
- R3: dn_claim for a downstream I/O access (dn_kind=1) follows command bit 0. When bit 0 is 0, I/O accesses are never claimed.
- R4: dn_claim for a downstream memory access (dn_kind=0) follows command bit 1. When bit 1 is 0, memory accesses are never claimed.
- R5: A downstream completion (dn_kind=2) is claimed whenever dn_valid is 1, whatever the command bits hold. dn_kind=3 and dn_valid=0 are never claimed.
- R6: With bus master enable at 1, an accepted upstream request appears on the fw_* outputs in the cycle after acceptance. Its kind, address, byte enables and data are unchanged, fw_illegal is 0, and no completion is produced. Kind codes: 0 memory read, 1 memory write, 2 I/O read, 3 I/O write, 4 message interrupt, 5 peer read, 6 peer write, 7 reserved, which is handled as a write.
- R7: With bus master enable at 0, every write-class kind (1, 3, 4, 6, 7) is forwarded as kind 1 to address 0xC0000, with byte enables 0, data unchanged and fw_illegal set to 1.
- R8: With bus master enable at 0, every read-class kind (0, 2, 5) is forwarded as kind 0 to address 0xC0000 with its byte enables kept and fw_illegal set to 1. In the cycle after acceptance, cpl_valid pulses for exactly one cycle with cpl_status=3'b001 (Unsupported Request).
- R9: up_ready equals (not fw_valid) or fw_ready. While fw_valid=1 and fw_ready=0, every fw_* output holds its value.
- R10: Status bit 8 (master data parity error) is set by perr_detect only while command bit 6 is 1. With bit 6 at 0, perr_detect leaves the bit unchanged.
- R11: Writing with cfg_sel=1 clears status bit 8 where wdata bit 8 is 1, and leaves it where wdata bit 8 is 0. If a set and a clear arrive in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects the command view, 1 selects the status view |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Read data of the selected view (combinational) |
| perr_detect | input | 1 | Master data parity error detected this cycle |
| dn_valid | input | 1 | Downstream access present |
| dn_kind | input | 2 | Downstream kind: 0 memory, 1 I/O, 2 completion, 3 none |
| dn_claim | output | 1 | Downstream access is accepted by this port |
| up_valid | input | 1 | Upstream request valid |
| up_ready | output | 1 | Upstream request accepted when high with up_valid |
| up_kind | input | 3 | Upstream request kind |
| up_addr | input | ADDR_W | Upstream request address |
| up_be | input | BE_W | Upstream byte enables |
| up_wdata | input | DATA_W | Upstream write data |
| fw_valid | output | 1 | Forwarded request valid |
| fw_ready | input | 1 | Primary side takes the forwarded request |
| fw_kind | output | 3 | Forwarded kind |
| fw_addr | output | ADDR_W | Forwarded address |
| fw_be | output | BE_W | Forwarded byte enables |
| fw_wdata | output | DATA_W | Forwarded data |
| fw_illegal | output | 1 | Request was rewritten because bus mastering was off |
| cpl_valid | output | 1 | Local completion for a rewritten read |
| cpl_status | output | 3 | Completion status, 3'b001 for Unsupported Request |

## Verification
The command register is swept through all 128 combinations of its low seven bits. The same value is repeated into the upper byte, so a stored reserved or hard-wired bit shows up in the readback. Each downstream kind is tried with each combination of the two space enables, which tells a swapped memory/I/O decode apart from a correct one and catches completions that are wrongly gated. Every upstream kind is sent once with bus mastering on and once with it off, which separates read-class from write-class rewriting and shows which kinds trigger the local completion. Held back-pressure, and parity events under both enable settings including a set and a clear in the same cycle, cover the handshake and the status bit.

// File: rtl/bcg_pkg.sv
`timescale 1ns/1ps
package bcg_pkg;

    typedef enum logic [2:0] {
        K_MEM_RD  = 3'd0,
        K_MEM_WR  = 3'd1,
        K_IO_RD   = 3'd2,
        K_IO_WR   = 3'd3,
        K_MSG     = 3'd4,
        K_PEER_RD = 3'd5,
        K_PEER_WR = 3'd6,
        K_RSVD    = 3'd7
    } up_kind_e;

    typedef enum logic [1:0] {
        D_MEM  = 2'd0,
        D_IO   = 2'd1,
        D_CPL  = 2'd2,
        D_NONE = 2'd3
    } dn_kind_e;

    typedef struct packed {
        logic perr_en;
        logic bme;
        logic mem_en;
        logic io_en;
    } cmd_bits_t;

    // Positions of the live bits inside the two 16-bit register views
    localparam int POS_IO   = 0;
    localparam int POS_MEM  = 1;
    localparam int POS_BME  = 2;
    localparam int POS_PERR = 6;
    localparam int POS_MDPE = 8;

    localparam logic [15:0] CMD_LIVE_MASK = 16'h0047;

    localparam logic [2:0] CPL_SC = 3'b000;
    localparam logic [2:0] CPL_UR = 3'b001;

    function automatic logic kind_is_read(input logic [2:0] k);
        return (k == K_MEM_RD) || (k == K_IO_RD) || (k == K_PEER_RD);
    endfunction

endpackage

// File: rtl/bcg_cmd_regs.sv
`timescale 1ns/1ps
module bcg_cmd_regs
    import bcg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic             cfg_sel,
    input  logic [15:0]      cfg_wdata,
    input  logic             perr_detect,
    output cmd_bits_t        cmd,
    output logic             mdpe,
    output logic [15:0]      cfg_rdata
);

    logic cmd_wr;
    logic sts_wr;
    logic mdpe_set;
    logic mdpe_clr;

    assign cmd_wr   = cfg_wr && !cfg_sel;
    assign sts_wr   = cfg_wr && cfg_sel;
    assign mdpe_set = perr_detect && cmd.perr_en;
    assign mdpe_clr = sts_wr && cfg_wdata[POS_MDPE];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd  <= '0;
            mdpe <= 1'b0;
        end else begin
            if (cmd_wr) begin
                cmd.io_en   <= cfg_wdata[POS_IO];
                cmd.mem_en  <= cfg_wdata[POS_MEM];
                cmd.bme     <= cfg_wdata[POS_BME];
                cmd.perr_en <= cfg_wdata[POS_PERR];
            end
            // set has priority over a same-cycle write-1-to-clear
            mdpe <= mdpe_set | (mdpe & ~mdpe_clr);
        end
    end

    logic [15:0] cmd_view;
    logic [15:0] sts_view;

    always_comb begin
        cmd_view           = '0;
        cmd_view[POS_IO]   = cmd.io_en;
        cmd_view[POS_MEM]  = cmd.mem_en;
        cmd_view[POS_BME]  = cmd.bme;
        cmd_view[POS_PERR] = cmd.perr_en;
        sts_view           = '0;
        sts_view[POS_MDPE] = mdpe;
    end

    assign cfg_rdata = cfg_sel ? sts_view : cmd_view;

    logic unused_wbits;
    assign unused_wbits = ^{cfg_wdata[15:9], cfg_wdata[7], cfg_wdata[5:3]};

endmodule

// File: rtl/bcg_dn_gate.sv
`timescale 1ns/1ps
module bcg_dn_gate
    import bcg_pkg::*;
(
    input  logic       dn_valid,
    input  logic [1:0] dn_kind,
    input  cmd_bits_t  cmd,
    output logic       dn_claim
);

    logic space_open;

    always_comb begin
        unique case (dn_kind)
            D_MEM:   space_open = cmd.mem_en;
            D_IO:    space_open = cmd.io_en;
            D_CPL:   space_open = 1'b1;   // completions never gated
            default: space_open = 1'b0;
        endcase
    end

    assign dn_claim = dn_valid && space_open;

    logic unused_cmd;
    assign unused_cmd = ^{cmd.bme, cmd.perr_en};

endmodule

// File: rtl/bcg_req_rewrite.sv
`timescale 1ns/1ps
module bcg_req_rewrite
    import bcg_pkg::*;
#(
    parameter int               ADDR_W      = 32,
    parameter int               BE_W        = 4,
    parameter logic [ADDR_W-1:0] LEGACY_ADDR = ADDR_W'(20'hC0000)
) (
    input  logic              bme,
    input  logic [2:0]        in_kind,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [BE_W-1:0]   in_be,
    output logic [2:0]        out_kind,
    output logic [ADDR_W-1:0] out_addr,
    output logic [BE_W-1:0]   out_be,
    output logic              out_illegal,
    output logic              out_need_ur
);

    logic is_rd;
    assign is_rd = kind_is_read(in_kind);

    always_comb begin
        out_kind    = in_kind;
        out_addr    = in_addr;
        out_be      = in_be;
        out_illegal = 1'b0;
        out_need_ur = 1'b0;
        if (!bme) begin
            out_illegal = 1'b1;
            out_addr    = LEGACY_ADDR;
            if (is_rd) begin
                out_kind    = K_MEM_RD;
                out_need_ur = 1'b1;
            end else begin
                out_kind = K_MEM_WR;
                out_be   = '0;
            end
        end
    end

endmodule

// File: rtl/bcg_fwd_stage.sv
`timescale 1ns/1ps
module bcg_fwd_stage
    import bcg_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BE_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [2:0]        in_kind,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [BE_W-1:0]   in_be,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic              in_illegal,
    input  logic              in_need_ur,
    output logic              fw_valid,
    input  logic              fw_ready,
    output logic [2:0]        fw_kind,
    output logic [ADDR_W-1:0] fw_addr,
    output logic [BE_W-1:0]   fw_be,
    output logic [DATA_W-1:0] fw_wdata,
    output logic              fw_illegal,
    output logic              cpl_valid,
    output logic [2:0]        cpl_status
);

    logic accept;

    assign in_ready = !fw_valid || fw_ready;
    assign accept   = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            fw_valid   <= 1'b0;
            fw_kind    <= '0;
            fw_addr    <= '0;
            fw_be      <= '0;
            fw_wdata   <= '0;
            fw_illegal <= 1'b0;
            cpl_valid  <= 1'b0;
            cpl_status <= CPL_SC;
        end else begin
            if (accept) begin
                fw_valid   <= 1'b1;
                fw_kind    <= in_kind;
                fw_addr    <= in_addr;
                fw_be      <= in_be;
                fw_wdata   <= in_wdata;
                fw_illegal <= in_illegal;
            end else if (fw_ready) begin
                fw_valid <= 1'b0;
            end
            cpl_valid  <= accept && in_need_ur;
            cpl_status <= (accept && in_need_ur) ? CPL_UR : CPL_SC;
        end
    end

endmodule

// File: rtl/bridge_cmd_gate.sv
`timescale 1ns/1ps
module bridge_cmd_gate
    import bcg_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter int                DATA_W      = 32,
    parameter int                BE_W        = DATA_W / 8,
    parameter logic [ADDR_W-1:0] LEGACY_ADDR = ADDR_W'(20'hC0000)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [15:0]       cfg_wdata,
    output logic [15:0]       cfg_rdata,
    input  logic              perr_detect,
    input  logic              dn_valid,
    input  logic [1:0]        dn_kind,
    output logic              dn_claim,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [2:0]        up_kind,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [BE_W-1:0]   up_be,
    input  logic [DATA_W-1:0] up_wdata,
    output logic              fw_valid,
    input  logic              fw_ready,
    output logic [2:0]        fw_kind,
    output logic [ADDR_W-1:0] fw_addr,
    output logic [BE_W-1:0]   fw_be,
    output logic [DATA_W-1:0] fw_wdata,
    output logic              fw_illegal,
    output logic              cpl_valid,
    output logic [2:0]        cpl_status
);

    cmd_bits_t         cmd;
    logic              mdpe;
    logic [2:0]        rw_kind;
    logic [ADDR_W-1:0] rw_addr;
    logic [BE_W-1:0]   rw_be;
    logic              rw_illegal;
    logic              rw_need_ur;

    bcg_cmd_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .cfg_wr      (cfg_wr),
        .cfg_sel     (cfg_sel),
        .cfg_wdata   (cfg_wdata),
        .perr_detect (perr_detect),
        .cmd         (cmd),
        .mdpe        (mdpe),
        .cfg_rdata   (cfg_rdata)
    );

    bcg_dn_gate u_dn (
        .dn_valid (dn_valid),
        .dn_kind  (dn_kind),
        .cmd      (cmd),
        .dn_claim (dn_claim)
    );

    bcg_req_rewrite #(
        .ADDR_W      (ADDR_W),
        .BE_W        (BE_W),
        .LEGACY_ADDR (LEGACY_ADDR)
    ) u_rw (
        .bme         (cmd.bme),
        .in_kind     (up_kind),
        .in_addr     (up_addr),
        .in_be       (up_be),
        .out_kind    (rw_kind),
        .out_addr    (rw_addr),
        .out_be      (rw_be),
        .out_illegal (rw_illegal),
        .out_need_ur (rw_need_ur)
    );

    bcg_fwd_stage #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BE_W   (BE_W)
    ) u_fwd (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (up_valid),
        .in_ready   (up_ready),
        .in_kind    (rw_kind),
        .in_addr    (rw_addr),
        .in_be      (rw_be),
        .in_wdata   (up_wdata),
        .in_illegal (rw_illegal),
        .in_need_ur (rw_need_ur),
        .fw_valid   (fw_valid),
        .fw_ready   (fw_ready),
        .fw_kind    (fw_kind),
        .fw_addr    (fw_addr),
        .fw_be      (fw_be),
        .fw_wdata   (fw_wdata),
        .fw_illegal (fw_illegal),
        .cpl_valid  (cpl_valid),
        .cpl_status (cpl_status)
    );

endmodule

// File: rtl/bcg_checker.sv
`timescale 1ns/1ps
module bcg_checker
    import bcg_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter int                BE_W        = 4,
    parameter logic [ADDR_W-1:0] LEGACY_ADDR = ADDR_W'(20'hC0000)
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_sel,
    input logic [15:0]       cfg_rdata,
    input logic              perr_detect,
    input logic              dn_valid,
    input logic [1:0]        dn_kind,
    input logic              dn_claim,
    input logic              up_valid,
    input logic              up_ready,
    input logic [2:0]        up_kind,
    input logic              fw_valid,
    input logic              fw_ready,
    input logic [2:0]        fw_kind,
    input logic [ADDR_W-1:0] fw_addr,
    input logic [BE_W-1:0]   fw_be,
    input logic              fw_illegal,
    input logic              cpl_valid,
    input logic              io_en,
    input logic              mem_en,
    input logic              bme,
    input logic              perr_en,
    input logic              mdpe
);

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !cfg_sel |-> ((cfg_rdata & ~CMD_LIVE_MASK) == 16'h0));

    assert_io_gate_R3: assert property (@(posedge clk) disable iff (rst)
        (dn_claim && dn_kind == 2'd1) |-> io_en);

    assert_mem_gate_R4: assert property (@(posedge clk) disable iff (rst)
        (dn_claim && dn_kind == 2'd0) |-> mem_en);

    assert_cpl_pass_R5: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && dn_kind == 2'd2) |-> dn_claim);

    assert_legacy_write_R7: assert property (@(posedge clk) disable iff (rst)
        (fw_valid && fw_illegal && !kind_is_read(fw_kind))
            |-> (fw_be == '0 && fw_addr == LEGACY_ADDR));

    assert_ur_source_R8: assert property (@(posedge clk) disable iff (rst)
        cpl_valid |-> $past(up_valid && up_ready && !bme && kind_is_read(up_kind)));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (fw_valid && !fw_ready) |=> (fw_valid && $stable(fw_addr) && $stable(fw_kind) && $stable(fw_be)));

    assert_perr_gate_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(mdpe) |-> $past(perr_en && perr_detect));

endmodule

bind bridge_cmd_gate bcg_checker #(
    .ADDR_W      (ADDR_W),
    .BE_W        (BE_W),
    .LEGACY_ADDR (LEGACY_ADDR)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_sel     (cfg_sel),
    .cfg_rdata   (cfg_rdata),
    .perr_detect (perr_detect),
    .dn_valid    (dn_valid),
    .dn_kind     (dn_kind),
    .dn_claim    (dn_claim),
    .up_valid    (up_valid),
    .up_ready    (up_ready),
    .up_kind     (up_kind),
    .fw_valid    (fw_valid),
    .fw_ready    (fw_ready),
    .fw_kind     (fw_kind),
    .fw_addr     (fw_addr),
    .fw_be       (fw_be),
    .fw_illegal  (fw_illegal),
    .cpl_valid   (cpl_valid),
    .io_en       (cmd.io_en),
    .mem_en      (cmd.mem_en),
    .bme         (cmd.bme),
    .perr_en     (cmd.perr_en),
    .mdpe        (mdpe)
);

// File: tb/bridge_cmd_gate_bench.sv
`timescale 1ns/1ps
module bridge_cmd_gate_bench;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int BW = DW / 8;
    localparam logic [AW-1:0] LEG = 32'h000C_0000;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_wr;
    logic          cfg_sel;
    logic [15:0]   cfg_wdata;
    logic [15:0]   cfg_rdata;
    logic          perr_detect;
    logic          dn_valid;
    logic [1:0]    dn_kind;
    logic          dn_claim;
    logic          up_valid;
    logic          up_ready;
    logic [2:0]    up_kind;
    logic [AW-1:0] up_addr;
    logic [BW-1:0] up_be;
    logic [DW-1:0] up_wdata;
    logic          fw_valid;
    logic          fw_ready;
    logic [2:0]    fw_kind;
    logic [AW-1:0] fw_addr;
    logic [BW-1:0] fw_be;
    logic [DW-1:0] fw_wdata;
    logic          fw_illegal;
    logic          cpl_valid;
    logic [2:0]    cpl_status;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    bridge_cmd_gate #(.ADDR_W(AW), .DATA_W(DW), .BE_W(BW), .LEGACY_ADDR(LEG)) u_bridge_cmd_gate (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .perr_detect(perr_detect), .dn_valid(dn_valid),
        .dn_kind(dn_kind), .dn_claim(dn_claim), .up_valid(up_valid), .up_ready(up_ready),
        .up_kind(up_kind), .up_addr(up_addr), .up_be(up_be), .up_wdata(up_wdata),
        .fw_valid(fw_valid), .fw_ready(fw_ready), .fw_kind(fw_kind), .fw_addr(fw_addr),
        .fw_be(fw_be), .fw_wdata(fw_wdata), .fw_illegal(fw_illegal),
        .cpl_valid(cpl_valid), .cpl_status(cpl_status)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic sel, input logic [15:0] d);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_wdata = '0;
    endtask

    task automatic rd_reg(input logic sel, output logic [15:0] d);
        cfg_sel = sel;
        #1 d = cfg_rdata;
    endtask

    function automatic logic is_rd(input int k);
        return (k == 0) || (k == 2) || (k == 5);
    endfunction

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] rv;
        rst = 1'b1; cfg_wr = 0; cfg_sel = 0; cfg_wdata = 0; perr_detect = 0;
        dn_valid = 0; dn_kind = 0; up_valid = 0; up_kind = 0; up_addr = 0;
        up_be = 0; up_wdata = 0; fw_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd_reg(1'b0, rv); chk("R1 cmd", rv, 0);
        rd_reg(1'b1, rv); chk("R1 sts", rv, 0);
        chk("R1 fw_valid", fw_valid, 0);
        chk("R1 cpl_valid", cpl_valid, 0);
        chk("R1 up_ready", up_ready, 1);

        // R2 full sweep of low seven bits, mirrored into the upper byte
        for (int v = 0; v < 128; v++) begin
            logic [15:0] w;
            w = {v[6:0], 2'b00, v[6:0]};
            wr_reg(1'b0, w);
            rd_reg(1'b0, rv);
            chk("R2 cmd readback", rv, w & 16'h0047);
        end

        // R3 R4 R5 downstream claim sweep
        for (int c = 0; c < 4; c++) begin
            wr_reg(1'b0, 16'(c));
            for (int k = 0; k < 4; k++) begin
                logic e;
                dn_kind = 2'(k);
                dn_valid = 1'b1;
                #1;
                e = (k == 0) ? c[1] : (k == 1) ? c[0] : (k == 2) ? 1'b1 : 1'b0;
                if (k == 1) chk("R3 io claim", dn_claim, e);
                else if (k == 0) chk("R4 mem claim", dn_claim, e);
                else chk("R5 cpl/none claim", dn_claim, e);
                dn_valid = 1'b0;
                #1 chk("R5 no valid no claim", dn_claim, 0);
                @(negedge clk);
            end
        end

        // R6 R7 R8 upstream rewrite sweep
        for (int b = 0; b < 2; b++) begin
            wr_reg(1'b0, b[0] ? 16'h0004 : 16'h0000);
            for (int k = 0; k < 8; k++) begin
                logic [AW-1:0] a;
                logic [BW-1:0] be;
                logic [DW-1:0] d;
                a  = 32'h1234_5000 + 32'(k * 36);
                be = 4'hF ^ 4'(k);
                d  = 32'hA5A5_0000 | 32'(k * 257);
                up_valid = 1'b1; up_kind = 3'(k); up_addr = a; up_be = be; up_wdata = d;
                #1 chk("R9 ready idle", up_ready, 1);
                @(negedge clk);
                up_valid = 1'b0;
                chk("R6 fw_valid", fw_valid, 1);
                chk("R6 fw_wdata", fw_wdata, d);
                if (b == 1) begin
                    chk("R6 kind", fw_kind, k);
                    chk("R6 addr", fw_addr, a);
                    chk("R6 be", fw_be, be);
                    chk("R6 illegal", fw_illegal, 0);
                    chk("R6 no cpl", cpl_valid, 0);
                end else if (is_rd(k)) begin
                    chk("R8 kind", fw_kind, 0);
                    chk("R8 addr", fw_addr, LEG);
                    chk("R8 be kept", fw_be, be);
                    chk("R8 illegal", fw_illegal, 1);
                    chk("R8 cpl_valid", cpl_valid, 1);
                    chk("R8 cpl_status", cpl_status, 3'b001);
                end else begin
                    chk("R7 kind", fw_kind, 1);
                    chk("R7 addr", fw_addr, LEG);
                    chk("R7 be cleared", fw_be, 0);
                    chk("R7 illegal", fw_illegal, 1);
                    chk("R7 no cpl", cpl_valid, 0);
                end
                @(negedge clk);
                chk("R6 fw drains", fw_valid, 0);
                chk("R8 cpl one cycle", cpl_valid, 0);
            end
        end

        // R9 back-pressure
        wr_reg(1'b0, 16'h0004);
        fw_ready = 1'b0;
        up_valid = 1'b1; up_kind = 3'd1; up_addr = 32'h0000_1111; up_be = 4'h3; up_wdata = 32'h1;
        @(negedge clk);
        up_addr = 32'h0000_2222; up_kind = 3'd3;
        #1 chk("R9 ready low", up_ready, 0);
        chk("R9 fw_valid", fw_valid, 1);
        repeat (2) @(negedge clk);
        chk("R9 held addr", fw_addr, 32'h0000_1111);
        chk("R9 held kind", fw_kind, 1);
        fw_ready = 1'b1;
        #1 chk("R9 ready follows fw_ready", up_ready, 1);
        @(negedge clk);
        up_valid = 1'b0;
        chk("R9 next addr", fw_addr, 32'h0000_2222);
        chk("R9 next kind", fw_kind, 3);
        @(negedge clk);
        chk("R9 empty", fw_valid, 0);

        // R10 parity status gating
        wr_reg(1'b0, 16'h0000);
        perr_detect = 1'b1; @(negedge clk); perr_detect = 1'b0;
        rd_reg(1'b1, rv); chk("R10 disabled no set", rv, 0);
        wr_reg(1'b0, 16'h0040);
        perr_detect = 1'b1; @(negedge clk); perr_detect = 1'b0;
        rd_reg(1'b1, rv); chk("R10 enabled set", rv, 16'h0100);

        // R11 write-1-to-clear
        wr_reg(1'b1, 16'hFEFF);
        rd_reg(1'b1, rv); chk("R11 write 0 keeps", rv, 16'h0100);
        wr_reg(1'b1, 16'h0100);
        rd_reg(1'b1, rv); chk("R11 write 1 clears", rv, 0);
        perr_detect = 1'b1;
        wr_reg(1'b1, 16'h0100);
        perr_detect = 1'b0;
        rd_reg(1'b1, rv); chk("R11 set wins", rv, 16'h0100);
        wr_reg(1'b0, 16'h0000);
        wr_reg(1'b1, 16'h0100);
        rd_reg(1'b1, rv); chk("R11 cleared with enable off", rv, 0);

        finish_run();
    end

endmodule